// File: doc/BRIEF.md
# I2C Target Register Bank

This block is an I2C target that lets a bus master read and write a small bank of 8-bit registers. The registers themselves live in the user logic; the block reaches them through a parallel port with a combinational read address/data pair and a one-cycle write strobe. SCL and SDA are taken from the pads, passed through two-flop synchronisers, and all bus events are found from edges of the synchronised copies. The only bus output is a pull-low enable for SDA, which the pad turns into an open-drain driver.

A write transaction carries a register index in its first data byte, and each later byte is stored at that index, which then advances. A read transaction carries no index; it streams registers starting wherever the index was left, advancing after each byte, until the master answers with a NACK. The block also answers the all-zero general-call byte. Indexes at or past the register count read as zero, and writes to them are dropped while the bytes are still acknowledged.

Top module: `i2c_regbank_target`

## Requirements
- R1: A START (synchronised SDA falling while SCL is high) begins address reception. A STOP (SDA rising while SCL is high) returns the block to idle with SDA released. After reset SDA is released and no write strobe is given.
- R2: An address byte whose upper 7 bits equal `dev_addr` is acknowledged by pulling SDA low for the ninth SCL clock. Bit 0 of that byte selects the direction: 1 is a read (target transmits), 0 is a write (target receives).
- R3: The address byte 0x00 (general call) is acknowledged and handled as a write.
- R4: Any other address byte is not acknowledged. The block then leaves SDA released and gives no write strobe until the next START.
- R5: In a write transaction the first data byte is loaded into the register index, no register is written, and the byte is acknowledged. Each write transaction clears the index-loaded state; a read transaction does not.
- R6: Every later data byte of a write is given on `rf_wdata` with the current index on `rf_waddr` and a one-cycle `rf_we` pulse, and is acknowledged; the index then advances by one (8-bit, wrapping).
- R7: A data byte whose index is not below REG_COUNT produces no `rf_we` pulse, is still acknowledged, and the index still advances.
- R8: In a read transaction the register at the index is sent MSB first over 8 SCL clocks, starting with no index byte from where the last transaction left the index; the index advances after each byte.
- R9: A read at an index not below REG_COUNT sends 0x00.
- R10: After each byte sent, SDA is released for the master's acknowledge. Low (ACK) makes the block send the next register; high (NACK) makes it stop sending and wait for a START.
- R11: SDA is never driven high; `sda_pull_o` only pulls low. It changes only while synchronised SCL is low, apart from the release at START or STOP.
- R12: A repeated START at any point, including inside a byte, abandons the current transfer without storing the partial byte and goes straight into address reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_addr | input | 7 | Device address this target answers to |
| scl_i | input | 1 | SCL line level from the pad |
| sda_i | input | 1 | SDA line level from the pad |
| sda_pull_o | output | 1 | 1 pulls SDA low, 0 releases it |
| rf_raddr | output | clog2(REG_COUNT) | Register index being read |
| rf_rdata | input | 8 | Contents of the register at `rf_raddr` |
| rf_we | output | 1 | One-cycle register write strobe |
| rf_waddr | output | clog2(REG_COUNT) | Register index to write |
| rf_wdata | output | 8 | Data to write |

## Verification
The assertions watch, on every cycle, that SDA moves only while synchronised SCL is low outside START/STOP, that a START lands in address reception with SDA free, that a STOP leaves the block idle and released, that idle never pulls SDA, and that every write strobe follows a loaded, in-range index. What goes over the bus only the bench scenarios show: address matching and rejection, general call, pointer loading and carry-over into later reads, zero data past the bank, the ACK/NACK handshake on reads, and a repeated START cutting a byte short. A behavioural model in the bench predicts every register write and every read byte, and each clock the write strobe is matched against its queue of predicted writes.

// File: rtl/i2crb_pkg.sv
package i2crb_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_DEC,
        ST_ADDR_ACK,
        ST_WR_BYTE,
        ST_WR_DEC,
        ST_WR_ACK,
        ST_RD_BYTE,
        ST_RD_ACK
    } link_state_e;

    // Events seen on the synchronised bus lines
    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    function automatic logic addr_hit(input logic [7:0] abyte, input logic [6:0] dev);
        return (abyte == 8'h00) || (abyte[7:1] == dev);
    endfunction

endpackage

// File: rtl/i2crb_sync.sv
module i2crb_sync
    import i2crb_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);

    logic [STAGES-1:0] scl_ff;
    logic [STAGES-1:0] sda_ff;
    logic              scl_q;
    logic              sda_q;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_ff[g] <= 1'b1;
                    sda_ff[g] <= 1'b1;
                end else begin
                    scl_ff[g] <= scl_i;
                    sda_ff[g] <= sda_i;
                end
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_ff[g] <= 1'b1;
                    sda_ff[g] <= 1'b1;
                end else begin
                    scl_ff[g] <= scl_ff[g-1];
                    sda_ff[g] <= sda_ff[g-1];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_ff[STAGES-1];
            sda_q <= sda_ff[STAGES-1];
        end
    end

    always_comb begin
        ev.scl      = scl_ff[STAGES-1];
        ev.sda      = sda_ff[STAGES-1];
        ev.scl_rise = ev.scl & ~scl_q;
        ev.scl_fall = ~ev.scl & scl_q;
        ev.start    = ev.scl & scl_q & sda_q & ~ev.sda;
        ev.stop     = ev.scl & scl_q & ~sda_q & ev.sda;
    end

endmodule

// File: rtl/i2crb_engine.sv
module i2crb_engine
    import i2crb_pkg::*;
#(
    parameter int REG_COUNT = 16,
    parameter int AW        = idx_w(REG_COUNT)
) (
    input  logic          clk,
    input  logic          rst,
    input  bus_ev_t       ev,
    input  logic [6:0]    dev_addr,
    input  logic [7:0]    rf_rdata,
    output logic [AW-1:0] rf_raddr,
    output logic          rf_we,
    output logic [AW-1:0] rf_waddr,
    output logic [7:0]    rf_wdata,
    output logic          sda_pull
);

    localparam int PTR_W = 8;

    link_state_e      state;
    logic [2:0]       cnt;
    logic [7:0]       sh;
    logic [PTR_W-1:0] ptr;
    logic             loaded;
    logic             rw;
    logic             nack;
    logic             in_range;
    logic [7:0]       tx_byte;

    assign in_range = ({1'b0, ptr} < 9'(REG_COUNT));
    assign tx_byte  = in_range ? rf_rdata : 8'h00;
    assign rf_raddr = ptr[AW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            sh       <= '0;
            ptr      <= '0;
            loaded   <= 1'b0;
            rw       <= 1'b0;
            nack     <= 1'b0;
            sda_pull <= 1'b0;
            rf_we    <= 1'b0;
            rf_waddr <= '0;
            rf_wdata <= '0;
        end else begin
            rf_we <= 1'b0;
            if (ev.start) begin
                state    <= ST_ADDR;
                cnt      <= '0;
                sda_pull <= 1'b0;
            end else if (ev.stop) begin
                state    <= ST_IDLE;
                sda_pull <= 1'b0;
            end else begin
                unique case (state)
                    ST_ADDR, ST_WR_BYTE: begin
                        if (ev.scl_rise) begin
                            sh  <= {sh[6:0], ev.sda};
                            cnt <= cnt + 3'd1;
                            if (cnt == 3'd7)
                                state <= (state == ST_ADDR) ? ST_ADDR_DEC : ST_WR_DEC;
                        end
                    end
                    ST_ADDR_DEC: begin
                        if (ev.scl_fall) begin
                            if (addr_hit(sh, dev_addr)) begin
                                sda_pull <= 1'b1;
                                rw       <= sh[0];
                                if (!sh[0]) loaded <= 1'b0;
                                state    <= ST_ADDR_ACK;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (ev.scl_fall) begin
                            cnt <= '0;
                            if (rw) begin
                                sh       <= tx_byte;
                                sda_pull <= ~tx_byte[7];
                                state    <= ST_RD_BYTE;
                            end else begin
                                sda_pull <= 1'b0;
                                state    <= ST_WR_BYTE;
                            end
                        end
                    end
                    ST_WR_DEC: begin
                        if (ev.scl_fall) begin
                            sda_pull <= 1'b1;
                            state    <= ST_WR_ACK;
                            if (!loaded) begin
                                ptr    <= sh;
                                loaded <= 1'b1;
                            end else begin
                                if (in_range) begin
                                    rf_we    <= 1'b1;
                                    rf_waddr <= ptr[AW-1:0];
                                    rf_wdata <= sh;
                                end
                                ptr <= ptr + 8'd1;
                            end
                        end
                    end
                    ST_WR_ACK: begin
                        if (ev.scl_fall) begin
                            sda_pull <= 1'b0;
                            cnt      <= '0;
                            state    <= ST_WR_BYTE;
                        end
                    end
                    ST_RD_BYTE: begin
                        if (ev.scl_fall) begin
                            if (cnt == 3'd7) begin
                                sda_pull <= 1'b0;
                                ptr      <= ptr + 8'd1;
                                state    <= ST_RD_ACK;
                            end else begin
                                cnt      <= cnt + 3'd1;
                                sh       <= {sh[6:0], 1'b0};
                                sda_pull <= ~sh[6];
                            end
                        end
                    end
                    ST_RD_ACK: begin
                        if (ev.scl_rise) nack <= ev.sda;
                        if (ev.scl_fall) begin
                            if (nack) begin
                                state <= ST_IDLE;
                            end else begin
                                sh       <= tx_byte;
                                sda_pull <= ~tx_byte[7];
                                cnt      <= '0;
                                state    <= ST_RD_BYTE;
                            end
                        end
                    end
                    default: begin
                        state <= ST_IDLE;
                    end
                endcase
            end
        end
    end

    // SDA moves only with SCL low, except the release at START/STOP
    assert_pull_scl_low_R11: assert property (@(posedge clk) disable iff (rst)
        (!$stable(sda_pull) && !$past(ev.start || ev.stop)) |-> !$past(ev.scl));

    assert_start_to_addr_R12: assert property (@(posedge clk) disable iff (rst)
        $past(ev.start) |-> (state == ST_ADDR) && !sda_pull);

    assert_stop_idle_R1: assert property (@(posedge clk) disable iff (rst)
        $past(ev.stop) |-> (state == ST_IDLE) && !sda_pull);

    assert_idle_released_R4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> !sda_pull);

    assert_write_in_range_R7: assert property (@(posedge clk) disable iff (rst)
        rf_we |-> $past(in_range) && $past(loaded));

endmodule

// File: rtl/i2c_regbank_target.sv
module i2c_regbank_target
    import i2crb_pkg::*;
#(
    parameter int REG_COUNT   = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [6:0]                  dev_addr,
    input  logic                        scl_i,
    input  logic                        sda_i,
    output logic                        sda_pull_o,
    output logic [idx_w(REG_COUNT)-1:0] rf_raddr,
    input  logic [7:0]                  rf_rdata,
    output logic                        rf_we,
    output logic [idx_w(REG_COUNT)-1:0] rf_waddr,
    output logic [7:0]                  rf_wdata
);

    localparam int AW = idx_w(REG_COUNT);

    bus_ev_t ev;

    i2crb_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    i2crb_engine #(
        .REG_COUNT (REG_COUNT),
        .AW        (AW)
    ) u_engine (
        .clk      (clk),
        .rst      (rst),
        .ev       (ev),
        .dev_addr (dev_addr),
        .rf_rdata (rf_rdata),
        .rf_raddr (rf_raddr),
        .rf_we    (rf_we),
        .rf_waddr (rf_waddr),
        .rf_wdata (rf_wdata),
        .sda_pull (sda_pull_o)
    );

endmodule

// File: tb/i2c_regbank_target_test.sv
module i2c_regbank_target_test;

    localparam int CLK_PERIOD = 10;
    localparam int REG_COUNT  = 16;
    localparam int AW         = 4;
    localparam int H          = 12;
    localparam logic [6:0] DEV = 7'h2A;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD / 2) clk = ~clk;

    logic          scl_m = 1'b1;
    logic          sda_m = 1'b1;
    logic          sda_pull;
    logic [AW-1:0] rf_raddr;
    logic [7:0]    rf_rdata;
    logic          rf_we;
    logic [AW-1:0] rf_waddr;
    logic [7:0]    rf_wdata;
    logic          sda_bus;

    assign sda_bus = sda_m & ~sda_pull;

    // user-side register file
    logic [7:0] rf_mem [REG_COUNT];
    assign rf_rdata = rf_mem[rf_raddr];
    always @(posedge clk) if (rf_we) rf_mem[rf_waddr] <= rf_wdata;

    i2c_regbank_target #(.REG_COUNT(REG_COUNT)) uut (
        .clk        (clk),
        .rst        (rst),
        .dev_addr   (DEV),
        .scl_i      (scl_m),
        .sda_i      (sda_bus),
        .sda_pull_o (sda_pull),
        .rf_raddr   (rf_raddr),
        .rf_rdata   (rf_rdata),
        .rf_we      (rf_we),
        .rf_waddr   (rf_waddr),
        .rf_wdata   (rf_wdata)
    );

    int total = 0;
    int fails = 0;
    int cyc   = 0;

    // behavioural reference model
    logic [7:0] mdl [REG_COUNT];
    int  mptr = 0;
    bit  mload = 1'b0;
    int  wq[$];

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            check(1'b0, "watchdog", cyc, 150000);
            summary();
        end
    end

    // every clock: compare write strobe with predicted write queue (R6, R7)
    always @(negedge clk) begin
        if (!rst && rf_we) begin
            if (wq.size() == 0) begin
                check(1'b0, "R7 unexpected write", {rf_waddr, rf_wdata}, 0);
            end else begin
                int e;
                e = wq.pop_front();
                check({24'd0, 4'd0, rf_waddr, rf_wdata} == e, "R6 write addr/data",
                      {rf_waddr, rf_wdata}, e);
            end
        end
    end

    task automatic m_wdata(input logic [7:0] b);
        if (!mload) begin
            mptr  = b;
            mload = 1'b1;
        end else begin
            if (mptr < REG_COUNT) begin
                wq.push_back((mptr << 8) | b);
                mdl[mptr] = b;
            end
            mptr = (mptr + 1) % 256;
        end
    endtask

    task automatic m_rdata(output logic [7:0] d);
        d    = (mptr < REG_COUNT) ? mdl[mptr] : 8'h00;
        mptr = (mptr + 1) % 256;
    endtask

    task automatic wclk(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wclk(H);
        scl_m = 1'b1; wclk(H);
        sda_m = 1'b0; wclk(H);
        scl_m = 1'b0; wclk(H);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wclk(H);
        scl_m = 1'b1; wclk(H);
        sda_m = 1'b1; wclk(H);
    endtask

    task automatic write_bit(input logic b);
        wclk(H / 2);
        sda_m = b;
        wclk(H / 2);
        scl_m = 1'b1; wclk(H);
        scl_m = 1'b0;
    endtask

    task automatic read_bit(output logic b, output logic b_late);
        sda_m = 1'b1; wclk(H);
        scl_m = 1'b1; wclk(H / 2);
        b = sda_bus;
        wclk(H / 2 - 1);
        b_late = sda_bus;
        wclk(1);
        scl_m = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        logic x, xl;
        for (int i = 7; i >= 0; i--) write_bit(b[i]);
        read_bit(x, xl);
        acked = !x;
    endtask

    task automatic recv_byte(output logic [7:0] d, input bit ack_it);
        logic x, xl;
        for (int i = 7; i >= 0; i--) begin
            read_bit(x, xl);
            d[i] = x;
            check(x == xl, "R11 SDA stable while SCL high", xl, x);
        end
        write_bit(ack_it ? 1'b0 : 1'b1);
    endtask

    task automatic do_write(input logic [7:0] abyte, input bit hit, input int n,
                            input logic [7:0] b0, input logic [7:0] b1,
                            input logic [7:0] b2, input logic [7:0] b3, input string tag);
        bit ak;
        logic [7:0] bs [4];
        bs[0] = b0; bs[1] = b1; bs[2] = b2; bs[3] = b3;
        bus_start();
        send_byte(abyte, ak);
        check(ak == hit, {tag, " address ack"}, ak, hit);
        if (hit) mload = 1'b0;
        for (int i = 0; i < n; i++) begin
            if (hit) m_wdata(bs[i]);
            send_byte(bs[i], ak);
            check(ak == hit, {tag, " data ack"}, ak, hit);
        end
    endtask

    task automatic do_read(input int n, input string tag);
        bit ak;
        logic [7:0] d, e;
        bus_start();
        send_byte({DEV, 1'b1}, ak);
        check(ak, "R2 read address ack", ak, 1);
        for (int i = 0; i < n; i++) begin
            m_rdata(e);
            recv_byte(d, i < n - 1);
            check(d == e, tag, d, e);
        end
        wclk(H / 2);
        check(sda_pull == 1'b0, "R10 released after NACK", sda_pull, 0);
    endtask

    initial begin
        for (int i = 0; i < REG_COUNT; i++) begin
            rf_mem[i] = 8'(8'h40 + i * 3);
            mdl[i]    = 8'(8'h40 + i * 3);
        end
        wclk(5);
        rst = 1'b0;
        wclk(2);
        check(sda_pull == 1'b0, "R1 reset SDA released", sda_pull, 0);
        check(rf_we == 1'b0, "R1 reset no write", rf_we, 0);

        // own address write: index 3, then two data bytes (R2, R5, R6)
        do_write({DEV, 1'b0}, 1'b1, 3, 8'h03, 8'h11, 8'h22, 8'h00, "R5 R6 write");
        bus_stop();
        wclk(H);
        check(sda_pull == 1'b0, "R1 released after STOP", sda_pull, 0);
        check(wq.size() == 0, "R6 all writes seen", wq.size(), 0);

        // read continues from index 5, ACK then NACK (R8, R10)
        do_read(2, "R8 read data");
        bus_stop();

        // general call: index 14, two in range, one beyond (R3, R7)
        do_write(8'h00, 1'b1, 4, 8'h0E, 8'hA5, 8'h5A, 8'h77, "R3 R7 general call");
        bus_stop();
        wclk(H);
        check(wq.size() == 0, "R7 no write beyond bank", wq.size(), 0);

        // index now 17: read returns zero (R9)
        do_read(1, "R9 out-of-range read");
        bus_stop();

        // foreign address: no ACK, no writes (R4)
        do_write({7'h13, 1'b0}, 1'b0, 2, 8'h01, 8'hEE, 8'h00, 8'h00, "R4 foreign address");
        check(sda_pull == 1'b0, "R4 SDA left released", sda_pull, 0);
        bus_stop();
        wclk(H);
        check(wq.size() == 0, "R4 no write", wq.size(), 0);

        // repeated START after index load, read from that index (R12, R5)
        do_write({DEV, 1'b0}, 1'b1, 1, 8'h02, 8'h00, 8'h00, 8'h00, "R12 index load");
        do_read(2, "R12 read after repeated START");
        bus_stop();

        // repeated START inside a data byte: partial byte dropped (R12)
        do_write({DEV, 1'b0}, 1'b1, 1, 8'h09, 8'h00, 8'h00, 8'h00, "R12 index load");
        for (int i = 0; i < 4; i++) write_bit(1'(i & 1));
        do_read(1, "R12 read after cut byte");
        bus_stop();
        wclk(H);
        check(wq.size() == 0, "R12 partial byte not stored", wq.size(), 0);

        // register file holds the model contents (R6)
        for (int i = 0; i < REG_COUNT; i++)
            check(rf_mem[i] == mdl[i], "R6 register contents", rf_mem[i], mdl[i]);

        summary();
    end

endmodule